// File: doc/BRIEF.md
# Partitioned Subword SIMD ALU

This block is a 64-bit integer datapath that can run as one full-width lane or be split into two 32-bit, four 16-bit or eight 8-bit independent lanes. A single opcode applies the same operation to every lane at once: wrapping add, wrapping subtract, unsigned absolute difference, or a sum-of-absolute-differences that also folds the per-lane differences into one scalar. Typical use is motion-estimation and image-filter kernels, where many narrow pixel values are processed per cycle through one wide arithmetic unit.

Carry chains are built from 8-bit segments. The lane mode decides which segment boundaries pass a carry and which cut it, so no carry or borrow crosses a lane edge. Operands are accepted when the input valid flag is high, and the packed result, the scalar sum and an output valid flag appear on registers one clock later.

Top module: `subword_simd_alu`

## Requirements
- R1: With opcode 2'b00 (add), each lane result equals the lane sum of `op_a` and `op_b` modulo 2^width, with lane mode 2'b00 one 64-bit lane, 2'b01 two 32-bit lanes, 2'b10 four 16-bit lanes, 2'b11 eight 8-bit lanes; lane k occupies bits [k*width +: width], and no carry crosses a lane boundary.
- R2: With opcode 2'b01 (subtract), each lane result equals `op_a` lane minus `op_b` lane modulo 2^width, with no borrow crossing a lane boundary.
- R3: With opcode 2'b10 (absolute difference), each lane result equals |a - b| with both lane values taken as unsigned.
- R4: With opcode 2'b11 (SAD), the packed result holds the per-lane absolute differences and `res_sum` holds their total, zero-extended to 65 bits so that no operand pair overflows it (all-ones against zero in 64-bit mode gives 2^64-1).
- R5: For opcodes other than SAD, `res_sum` is zero.
- R6: Results from operands accepted with `in_valid` high appear one clock later, and `out_valid` equals `in_valid` delayed by one clock.
- R7: When `in_valid` is low, `res_packed` and `res_sum` keep their previous values whatever the other inputs do.
- R8: While `rst_n` is low, `out_valid`, `res_packed` and `res_sum` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are accepted this cycle |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| lane_mode | input | 2 | Lane split: 00 x64, 01 x32, 10 x16, 11 x8 |
| opcode | input | 2 | 00 add, 01 subtract, 10 absolute difference, 11 SAD |
| out_valid | output | 1 | Result registers hold a new result |
| res_packed | output | 64 | Packed per-lane result |
| res_sum | output | 65 | Scalar SAD reduction, zero unless the opcode was SAD |

## Verification
The hardest case to reach is a carry that must ripple through every segment of a wide lane while being stopped at each boundary in a narrower mode, since random operands rarely make a run of all-ones bytes. Directed operands of all-ones against one are applied in each of the four modes for add and zero against one for subtract, and SAD is driven with all-ones against zero in every mode to hit each mode's maximum sum. A long random phase then mixes modes, opcodes and idle cycles, with operand bytes biased toward 0x00 and 0xFF so that lane-edge carries and borrows keep recurring.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_ABSD = 2'b10,
      OP_SAD  = 2'b11
   } alu_op_e;

   typedef enum logic [1:0] {
      LM_X1 = 2'b00,
      LM_X2 = 2'b01,
      LM_X4 = 2'b10,
      LM_X8 = 2'b11
   } lane_mode_e;

endpackage

// File: rtl/lane_edge_map.sv
module lane_edge_map #(
   parameter int NSEG = 8
) (
   input  logic [1:0]      mode,
   output logic [NSEG-1:0] seg_first,
   output logic [NSEG-1:0] seg_last
);
   localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1;

   logic [IW:0] lane_segs;

   always_comb begin
      lane_segs = (IW+1)'(NSEG >> mode);
   end

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      localparam logic [IW:0] IDX = (IW+1)'(i);
      always_comb begin
         seg_first[i] = ((IDX & (lane_segs - 1'b1)) == '0);
         seg_last[i]  = ((IDX & (lane_segs - 1'b1)) == (lane_segs - 1'b1));
      end
   end
endmodule

// File: rtl/seg_carry_adder.sv
module seg_carry_adder #(
   parameter int DW  = 64,
   parameter int SEG = 8
) (
   input  logic [DW-1:0]      x,
   input  logic [DW-1:0]      y,
   input  logic               cin,
   input  logic [DW/SEG-1:0]  seg_first,
   output logic [DW-1:0]      sum,
   output logic [DW/SEG-1:0]  seg_cout
);
   localparam int NSEG = DW / SEG;

   logic [NSEG-1:0] seg_cin;

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      logic [SEG:0] part;
      if (i == 0) begin : g_lsb
         assign seg_cin[i] = cin;
      end else begin : g_chain
         assign seg_cin[i] = seg_first[i] ? cin : seg_cout[i-1];
      end
      always_comb begin
         part = {1'b0, x[i*SEG +: SEG]} + {1'b0, y[i*SEG +: SEG]}
              + {{SEG{1'b0}}, seg_cin[i]};
      end
      assign sum[i*SEG +: SEG] = part[SEG-1:0];
      assign seg_cout[i]       = part[SEG];
   end
endmodule

// File: rtl/sad_fold.sv
module sad_fold #(
   parameter int DW   = 64,
   parameter int SEG  = 8,
   parameter int SUMW = DW + 1
) (
   input  logic [DW-1:0]   absd,
   input  logic [1:0]      mode,
   output logic [SUMW-1:0] total
);
   localparam int NSEG = DW / SEG;

   always_comb begin
      int lane_segs;
      lane_segs = NSEG >> mode;
      total = '0;
      for (int i = 0; i < NSEG; i++) begin
         total = total + (SUMW'(absd[i*SEG +: SEG]) << (SEG * (i % lane_segs)));
      end
   end
endmodule

// File: rtl/subword_simd_alu.sv
module subword_simd_alu
   import simd_lane_pkg::*;
#(
   parameter int DW   = 64,
   parameter int SEG  = 8,
   parameter int SUMW = DW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [DW-1:0]   op_a,
   input  logic [DW-1:0]   op_b,
   input  logic [1:0]      lane_mode,
   input  logic [1:0]      opcode,
   output logic            out_valid,
   output logic [DW-1:0]   res_packed,
   output logic [SUMW-1:0] res_sum
);
   localparam int NSEG = DW / SEG;

   if (DW % SEG != 0) begin : g_bad_div
      $error("DW must be a multiple of SEG");
   end
   if (NSEG < 8) begin : g_bad_nseg
      $error("eight-lane mode needs at least eight segments");
   end
   if (SUMW < DW + 1) begin : g_bad_sumw
      $error("SUMW too narrow for the largest reduction");
   end

   alu_op_e         op;
   logic [NSEG-1:0] seg_first;
   logic [NSEG-1:0] seg_last;
   logic [DW-1:0]   ab_y;
   logic            ab_cin;
   logic [DW-1:0]   ab_sum;
   logic [NSEG-1:0] ab_cout;
   logic [DW-1:0]   ba_sum;
   logic [NSEG-1:0] ba_cout;
   logic [DW-1:0]   absd;
   logic [SUMW-1:0] sad_total;
   logic [DW-1:0]   nxt_packed;
   logic [SUMW-1:0] nxt_sum;

   assign op = alu_op_e'(opcode);

   lane_edge_map #(.NSEG(NSEG)) u_edges (
      .mode      (lane_mode),
      .seg_first (seg_first),
      .seg_last  (seg_last)
   );

   // a + b for add, a + ~b + 1 for every other opcode
   always_comb begin
      ab_y   = (op == OP_ADD) ? op_b : ~op_b;
      ab_cin = (op != OP_ADD);
   end

   seg_carry_adder #(.DW(DW), .SEG(SEG)) u_ab (
      .x         (op_a),
      .y         (ab_y),
      .cin       (ab_cin),
      .seg_first (seg_first),
      .sum       (ab_sum),
      .seg_cout  (ab_cout)
   );

   seg_carry_adder #(.DW(DW), .SEG(SEG)) u_ba (
      .x         (op_b),
      .y         (~op_a),
      .cin       (1'b1),
      .seg_first (seg_first),
      .sum       (ba_sum),
      .seg_cout  (ba_cout)
   );

   // lane-wide choice: carry out of the lane's top segment of a-b means a >= b
   always_comb begin
      int lane_segs;
      int top;
      lane_segs = NSEG >> lane_mode;
      absd = '0;
      for (int i = 0; i < NSEG; i++) begin
         top = i | (lane_segs - 1);
         absd[i*SEG +: SEG] = ab_cout[top] ? ab_sum[i*SEG +: SEG]
                                           : ba_sum[i*SEG +: SEG];
      end
   end

   sad_fold #(.DW(DW), .SEG(SEG), .SUMW(SUMW)) u_fold (
      .absd  (absd),
      .mode  (lane_mode),
      .total (sad_total)
   );

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: nxt_packed = ab_sum;
         default:        nxt_packed = absd;
      endcase
      nxt_sum = (op == OP_SAD) ? sad_total : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         res_packed <= '0;
         res_sum    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_packed <= nxt_packed;
            res_sum    <= nxt_sum;
         end
      end
   end

   // R6: valid flag tracks the input flag with one cycle of delay
   a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R7: idle cycles leave results untouched
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_packed) && $stable(res_sum)));

   // R5: scalar output is zero for non-reduction opcodes
   a_r5_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode != OP_SAD) |=> (res_sum == '0));

   // R1: in eight-lane add, byte 1 ignores any carry out of byte 0
   a_r1_byte_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_ADD && lane_mode == LM_X8) |=>
      (res_packed[2*SEG-1:SEG] == $past(op_a[2*SEG-1:SEG] + op_b[2*SEG-1:SEG])));

   // R3: low byte of an eight-lane absolute difference is unsigned |a-b|
   a_r3_absd_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_ABSD && lane_mode == LM_X8) |=>
      (res_packed[SEG-1:0] == (($past(op_a[SEG-1:0]) >= $past(op_b[SEG-1:0]))
                               ? ($past(op_a[SEG-1:0]) - $past(op_b[SEG-1:0]))
                               : ($past(op_b[SEG-1:0]) - $past(op_a[SEG-1:0])))));

   // R4: in eight-lane SAD the scalar cannot exceed eight maximal bytes
   a_r4_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_SAD && lane_mode == LM_X8) |=>
      (res_sum <= SUMW'(NSEG * ((1 << SEG) - 1))));

endmodule

// File: tb/sim_subword_simd_alu.sv
`timescale 1ns/1ps
module sim_subword_simd_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [1:0]  lane_mode = '0;
   logic [1:0]  opcode = '0;
   logic        out_valid;
   logic [63:0] res_packed;
   logic [64:0] res_sum;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   subword_simd_alu u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .op_a       (op_a),
      .op_b       (op_b),
      .lane_mode  (lane_mode),
      .opcode     (opcode),
      .out_valid  (out_valid),
      .res_packed (res_packed),
      .res_sum    (res_sum)
   );

   // behavioural reference: lane-by-lane integer arithmetic
   function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] m, input logic [1:0] op,
                                  output logic [63:0] p, output logic [64:0] s);
      int lw;
      int nl;
      logic [63:0] mask;
      logic [63:0] x;
      logic [63:0] y;
      logic [63:0] r;
      lw = 64 >> m;
      nl = 1 << m;
      mask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
      p = '0;
      s = '0;
      for (int k = 0; k < nl; k++) begin
         x = (a >> (k * lw)) & mask;
         y = (b >> (k * lw)) & mask;
         case (op)
            2'd0:    r = x + y;
            2'd1:    r = x - y;
            default: r = (x >= y) ? (x - y) : (y - x);
         endcase
         r = r & mask;
         p = p | (r << (k * lw));
         if (op == 2'd3) s = s + {1'b0, r};
      end
   endfunction

   logic [63:0] exp_p;
   logic [64:0] exp_s;
   logic        exp_v;
   string       tag_p;
   string       tag_s;

   always @(posedge clk or negedge rst_n) begin
      logic [63:0] p;
      logic [64:0] s;
      if (!rst_n) begin
         exp_p <= '0;
         exp_s <= '0;
         exp_v <= 1'b0;
         tag_p <= "R8";
         tag_s <= "R8";
      end else begin
         exp_v <= in_valid;
         if (in_valid) begin
            ref_op(op_a, op_b, lane_mode, opcode, p, s);
            exp_p <= p;
            exp_s <= s;
            case (opcode)
               2'd0:    tag_p <= "R1";
               2'd1:    tag_p <= "R2";
               2'd2:    tag_p <= "R3";
               default: tag_p <= "R4";
            endcase
            tag_s <= (opcode == 2'd3) ? "R4" : "R5";
         end else begin
            tag_p <= "R7";
            tag_s <= "R7";
         end
      end
   end

   task automatic check(input string req, input string what,
                        input logic [64:0] act, input logic [64:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare against the reference on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check("R8", "reset valid", {64'd0, out_valid}, 65'd0);
            check("R8", "reset packed", {1'b0, res_packed}, 65'd0);
            check("R8", "reset sum", res_sum, 65'd0);
         end else begin
            check("R6", "out_valid", {64'd0, out_valid}, {64'd0, exp_v});
            check(tag_p, "res_packed", {1'b0, res_packed}, {1'b0, exp_p});
            check(tag_s, "res_sum", res_sum, exp_s);
         end
      end
   end

   task automatic issue(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] m, input logic [1:0] op);
      @(negedge clk);
      #1;
      in_valid  = 1'b1;
      op_a      = a;
      op_b      = b;
      lane_mode = m;
      opcode    = op;
   endtask

   task automatic idle(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] m, input logic [1:0] op);
      @(negedge clk);
      #1;
      in_valid  = 1'b0;
      op_a      = a;
      op_b      = b;
      lane_mode = m;
      opcode    = op;
   endtask

   function automatic logic [63:0] biased_word();
      logic [63:0] w;
      for (int i = 0; i < 8; i++) begin
         case ($urandom_range(0, 3))
            0:       w[i*8 +: 8] = 8'h00;
            1:       w[i*8 +: 8] = 8'hFF;
            default: w[i*8 +: 8] = 8'($urandom);
         endcase
      end
      return w;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1: carry ripples through full lane or stops at each lane edge
      for (int m = 0; m < 4; m++) issue({64{1'b1}}, 64'h0101_0101_0101_0101, 2'(m), 2'd0);
      for (int m = 0; m < 4; m++) issue(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'(m), 2'd0);
      // R2: borrow confined to each lane
      for (int m = 0; m < 4; m++) issue(64'd0, 64'h0101_0101_0101_0101, 2'(m), 2'd1);
      for (int m = 0; m < 4; m++) issue(64'h1000_0000_0000_0000, 64'd1, 2'(m), 2'd1);
      // R3: both operand orders
      for (int m = 0; m < 4; m++) issue(64'h05FA_0100_8000_7F80, 64'hFA05_00FF_7FFF_807F, 2'(m), 2'd2);
      for (int m = 0; m < 4; m++) issue(64'hFA05_00FF_7FFF_807F, 64'h05FA_0100_8000_7F80, 2'(m), 2'd2);
      // R4: maximum reduction in each mode
      for (int m = 0; m < 4; m++) issue({64{1'b1}}, 64'd0, 2'(m), 2'd3);
      for (int m = 0; m < 4; m++) issue(64'd0, {64{1'b1}}, 2'(m), 2'd3);
      // R7: idle cycles with wild inputs
      for (int k = 0; k < 4; k++) idle(biased_word(), biased_word(), 2'(k), 2'(3 - k));
      // R5 then R7 after a SAD
      issue(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 2'd3, 2'd3);
      idle(64'd0, {64{1'b1}}, 2'd0, 2'd0);
      issue(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 2'd3, 2'd2);

      // mixed random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 3) == 0)
            idle(biased_word(), biased_word(), 2'($urandom), 2'($urandom));
         else
            issue(biased_word(), biased_word(), 2'($urandom), 2'($urandom));
      end
      idle(64'd0, 64'd0, 2'd0, 2'd0);
      repeat (2) @(negedge clk);
      #2;
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule